// File: doc/BRIEF.md
# Transmit Mailbox Abort Controller

This block tracks cancellation requests for a small bank of transmit mailboxes in a message controller. Software asks to cancel a queued frame by writing the cancel code into a mailbox's 4-bit code field. The controller decides what happens to that write. If the mailbox is not yet in the hands of the transmitter, the write takes effect at once and the mailbox goes quiet. If the transmitter has already claimed the mailbox, the write is refused and the request is remembered.

A remembered request ends in one of two ways, decided by the next bus event for that mailbox:

- **Cancelled.** A lost arbitration, a transmit error or entry into freeze mode cancels the frame. The cancel code lands in the code field and the mailbox flag rises.
- **Sent anyway.** A completed transmission writes a separate completion code and also raises the flag.

Software can therefore read the code to tell the two outcomes apart. Software clears a flag by writing 1 to it. A per-mailbox enable decides whether a raised flag drives the interrupt line. The whole mechanism only applies while the cancel-enable input is high. With the enable low, the cancel code is stored like any other code value.

Top module: `abt_mailbox_ctrl`

## Requirements
- R1: After reset every code field reads 4'b1000 (inactive), all flags are 0 and irq is 0.
- R2: With abort_en low, a write of 4'b1001 is stored in the code field on the next cycle even when the mailbox is locked. No flag is set and no request is held, so a later arbitration loss changes nothing.
- R3: With abort_en high and the mailbox not locked (tx_busy_valid low or tx_busy_idx different), a write of 4'b1001 is stored on the next cycle and the flag stays 0.
- R4: With abort_en high and the mailbox locked, a write of 4'b1001 is refused: the code field keeps its previous value, the flag stays 0 and a request is held pending.
- R5: A pending request on the locked mailbox resolves on ev_arb_lost or ev_tx_err. On the next cycle the code field is 4'b1001 and the flag is 1.
- R6: ev_freeze resolves every pending request, locked or not. The code field becomes 4'b1001 and the flag becomes 1.
- R7: ev_tx_done on the locked mailbox that has a pending request stores 4'b1010 (done) and sets the flag. The request is dropped, so a later ev_arb_lost has no effect.
- R8: ev_tx_done on a locked mailbox without a request also stores 4'b1010 and sets the flag. ev_arb_lost and ev_tx_err without a request leave the code field and flag unchanged.
- R9: irq is high exactly when some mailbox has both its flag and its irq_en bit set.
- R10: Writing 1 to bit i of flag_clr clears flag i. If the flag is set in the same cycle, the set wins.
- R11: A refused cancel write in the same cycle as ev_arb_lost resolves as cancelled (4'b1001, flag 1). In the same cycle as ev_tx_done it resolves as done (4'b1010, flag 1). Completion wins over any cancel trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| abort_en | input | 1 | Enables the cancel mechanism |
| wr_en | input | 1 | Code-field write strobe |
| wr_idx | input | IDX_W | Mailbox addressed by the write |
| wr_code | input | 4 | Code value written |
| tx_busy_valid | input | 1 | A mailbox is locked by the transmitter |
| tx_busy_idx | input | IDX_W | Index of the locked mailbox |
| ev_arb_lost | input | 1 | Arbitration lost for the locked mailbox |
| ev_tx_err | input | 1 | Transmit error for the locked mailbox |
| ev_freeze | input | 1 | Freeze-mode entry |
| ev_tx_done | input | 1 | Locked mailbox transmitted successfully |
| flag_clr | input | NUM_MB | Write-1-to-clear of flags |
| irq_en | input | NUM_MB | Per-mailbox interrupt enable |
| mb_code | output | 4*NUM_MB | Code fields, mailbox i at bits 4i+3:4i |
| mb_flag | output | NUM_MB | Mailbox flags |
| irq | output | 1 | Gated interrupt request |

## Verification
The cancel write from software and the bus outcome from the transmitter can land in the same clock on the same mailbox. The bench provokes this by driving a cancel write to the locked mailbox together with either an arbitration-loss strobe or a completion strobe. It judges the result by the code and flag one cycle later: cancel code with flag, or completion code with flag, and never a stale active code. A second collision drives flag_clr in the cycle a completion sets the same flag, and expects the flag to remain set.

// File: rtl/abt_pkg.sv
package abt_pkg;
  typedef logic [3:0] code_t;

  localparam code_t CODE_INACTIVE = 4'b1000;
  localparam code_t CODE_ACTIVE   = 4'b1100;
  localparam code_t CODE_ABORT    = 4'b1001;
  localparam code_t CODE_DONE     = 4'b1010;

  // An event that cancels a held request for one mailbox.
  function automatic logic f_cancel_trigger(input logic locked, input logic arb,
                                            input logic err, input logic frz);
    return (locked && (arb || err)) || frz;
  endfunction

  function automatic logic f_is_abort(input code_t c);
    return c == CODE_ABORT;
  endfunction
endpackage

// File: rtl/abt_slot.sv
module abt_slot
  import abt_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int MY_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort_en,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  code_t            wr_code,
  input  logic             tx_busy_valid,
  input  logic [IDX_W-1:0] tx_busy_idx,
  input  logic             ev_arb_lost,
  input  logic             ev_tx_err,
  input  logic             ev_freeze,
  input  logic             ev_tx_done,
  input  logic             flag_clr,
  output code_t            code_q,
  output logic             flag_q,
  output logic             pend_q,
  output logic             blocked_o,
  output logic             res_abort_o,
  output logic             res_done_o
);
  localparam logic [IDX_W-1:0] SELF = IDX_W'(MY_IDX);

  logic locked, wr_hit, pend_now, trig;

  assign locked      = tx_busy_valid && (tx_busy_idx == SELF);
  assign wr_hit      = wr_en && (wr_idx == SELF);
  assign blocked_o   = wr_hit && f_is_abort(wr_code) && abort_en && locked;
  assign pend_now    = pend_q || blocked_o;
  assign trig        = f_cancel_trigger(locked, ev_arb_lost, ev_tx_err, ev_freeze);
  assign res_done_o  = locked && ev_tx_done;
  assign res_abort_o = pend_now && trig && !res_done_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_INACTIVE;
      pend_q <= 1'b0;
    end else if (res_done_o) begin
      code_q <= CODE_DONE;
      pend_q <= 1'b0;
    end else if (res_abort_o) begin
      code_q <= CODE_ABORT;
      pend_q <= 1'b0;
    end else if (blocked_o) begin
      pend_q <= 1'b1;
    end else if (wr_hit) begin
      code_q <= wr_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         flag_q <= 1'b0;
    else if (res_done_o || res_abort_o) flag_q <= 1'b1;
    else if (flag_clr)                  flag_q <= 1'b0;
  end
endmodule

// File: rtl/abt_irq_gen.sv
module abt_irq_gen #(
  parameter int NUM_MB = 4
) (
  input  logic [NUM_MB-1:0] flag,
  input  logic [NUM_MB-1:0] en,
  output logic              irq
);
  assign irq = |(flag & en);
endmodule

// File: rtl/abt_mailbox_ctrl.sv
module abt_mailbox_ctrl
  import abt_pkg::*;
#(
  parameter int NUM_MB = 4,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                abort_en,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [3:0]          wr_code,
  input  logic                tx_busy_valid,
  input  logic [IDX_W-1:0]    tx_busy_idx,
  input  logic                ev_arb_lost,
  input  logic                ev_tx_err,
  input  logic                ev_freeze,
  input  logic                ev_tx_done,
  input  logic [NUM_MB-1:0]   flag_clr,
  input  logic [NUM_MB-1:0]   irq_en,
  output logic [4*NUM_MB-1:0] mb_code,
  output logic [NUM_MB-1:0]   mb_flag,
  output logic                irq
);
  logic [NUM_MB-1:0] pend_vec, blk_vec, res_abort_vec, res_done_vec;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_slot
    code_t c;
    abt_slot #(.IDX_W(IDX_W), .MY_IDX(i)) u_slot (
      .clk(clk), .rst_n(rst_n), .abort_en(abort_en),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_code(wr_code),
      .tx_busy_valid(tx_busy_valid), .tx_busy_idx(tx_busy_idx),
      .ev_arb_lost(ev_arb_lost), .ev_tx_err(ev_tx_err),
      .ev_freeze(ev_freeze), .ev_tx_done(ev_tx_done),
      .flag_clr(flag_clr[i]),
      .code_q(c), .flag_q(mb_flag[i]), .pend_q(pend_vec[i]),
      .blocked_o(blk_vec[i]), .res_abort_o(res_abort_vec[i]),
      .res_done_o(res_done_vec[i])
    );
    assign mb_code[4*i +: 4] = c;
  end

  abt_irq_gen #(.NUM_MB(NUM_MB)) u_irq (
    .flag(mb_flag), .en(irq_en), .irq(irq)
  );
endmodule

// File: rtl/abt_checker.sv
module abt_checker
  import abt_pkg::*;
#(
  parameter int NUM_MB = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                abort_en,
  input logic [4*NUM_MB-1:0] mb_code,
  input logic [NUM_MB-1:0]   mb_flag,
  input logic                irq,
  input logic [NUM_MB-1:0]   pend_vec,
  input logic [NUM_MB-1:0]   blk_vec,
  input logic [NUM_MB-1:0]   res_abort_vec,
  input logic [NUM_MB-1:0]   res_done_vec
);
  p_no_flag_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_flag == '0) |-> !irq);

  for (genvar i = 0; i < NUM_MB; i++) begin : g_chk
    p_abort_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_abort_vec[i] |=> (mb_flag[i] && mb_code[4*i +: 4] == CODE_ABORT));

    p_done_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_done_vec[i] |=> (mb_flag[i] && mb_code[4*i +: 4] == CODE_DONE));

    p_request_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_abort_vec[i] || res_done_vec[i]) |=> !pend_vec[i]);

    p_refused_keeps_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_vec[i] && !res_abort_vec[i] && !res_done_vec[i]) |=>
        ($stable(mb_code[4*i +: 4]) && pend_vec[i]));

    p_pending_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_vec[i]) |-> $past(abort_en));
  end
endmodule

bind abt_mailbox_ctrl abt_checker #(.NUM_MB(NUM_MB)) u_abt_chk (
  .clk(clk), .rst_n(rst_n), .abort_en(abort_en),
  .mb_code(mb_code), .mb_flag(mb_flag), .irq(irq),
  .pend_vec(pend_vec), .blk_vec(blk_vec),
  .res_abort_vec(res_abort_vec), .res_done_vec(res_done_vec)
);

// File: tb/abt_mailbox_ctrl_bench.sv
module abt_mailbox_ctrl_bench;
  localparam int NUM_MB = 4;
  localparam int IDX_W = 2;
  localparam logic [3:0] K_IDLE = 4'b1000, K_ACT = 4'b1100,
                         K_ABT = 4'b1001, K_DONE = 4'b1010;

  logic clk = 0, rst_n = 0;
  logic abort_en = 0, wr_en = 0, tx_busy_valid = 0;
  logic [IDX_W-1:0] wr_idx = '0, tx_busy_idx = '0;
  logic [3:0] wr_code = '0;
  logic ev_arb_lost = 0, ev_tx_err = 0, ev_freeze = 0, ev_tx_done = 0;
  logic [NUM_MB-1:0] flag_clr = '0, irq_en = '0;
  logic [4*NUM_MB-1:0] mb_code;
  logic [NUM_MB-1:0] mb_flag;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  abt_mailbox_ctrl #(.NUM_MB(NUM_MB)) u_abt_mailbox_ctrl (
    .clk(clk), .rst_n(rst_n), .abort_en(abort_en), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_code(wr_code), .tx_busy_valid(tx_busy_valid),
    .tx_busy_idx(tx_busy_idx), .ev_arb_lost(ev_arb_lost), .ev_tx_err(ev_tx_err),
    .ev_freeze(ev_freeze), .ev_tx_done(ev_tx_done), .flag_clr(flag_clr),
    .irq_en(irq_en), .mb_code(mb_code), .mb_flag(mb_flag), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] code_of(input int i);
    return mb_code[4*i +: 4];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; abort_en = 0; wr_en = 0; tx_busy_valid = 0;
    ev_arb_lost = 0; ev_tx_err = 0; ev_freeze = 0; ev_tx_done = 0;
    flag_clr = '0; irq_en = '0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  // one-cycle write; outputs are sampled at the following negedge
  task automatic wr(input int idx, input logic [3:0] c);
    wr_en = 1; wr_idx = IDX_W'(idx); wr_code = c;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic lock(input int idx);
    tx_busy_valid = 1; tx_busy_idx = IDX_W'(idx);
  endtask

  task automatic pulse(input logic a, input logic e, input logic f, input logic d);
    ev_arb_lost = a; ev_tx_err = e; ev_freeze = f; ev_tx_done = d;
    @(negedge clk);
    ev_arb_lost = 0; ev_tx_err = 0; ev_freeze = 0; ev_tx_done = 0;
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < NUM_MB; i++) chk("R1 code", code_of(i), K_IDLE);
    chk("R1 flags", mb_flag, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_disabled();
    do_reset();
    wr(1, K_ACT); lock(1);
    wr(1, K_ABT);
    chk("R2 code stored", code_of(1), K_ABT);
    chk("R2 no flag", mb_flag[1], 0);
    pulse(1, 0, 0, 0);
    chk("R2 no pending", mb_flag[1], 0);
  endtask

  task automatic t_idle_abort();
    do_reset(); abort_en = 1;
    wr(2, K_ACT); lock(0);
    wr(2, K_ABT);
    chk("R3 code", code_of(2), K_ABT);
    chk("R3 no flag", mb_flag[2], 0);
  endtask

  task automatic t_refused(input int kind);
    do_reset(); abort_en = 1;
    wr(3, K_ACT); lock(3);
    wr(3, K_ABT);
    chk("R4 code held", code_of(3), K_ACT);
    chk("R4 no flag", mb_flag[3], 0);
    if (kind == 0) begin
      pulse(1, 0, 0, 0);
      chk("R5 arb code", code_of(3), K_ABT); chk("R5 arb flag", mb_flag[3], 1);
    end else if (kind == 1) begin
      pulse(0, 1, 0, 0);
      chk("R5 err code", code_of(3), K_ABT); chk("R5 err flag", mb_flag[3], 1);
    end else if (kind == 2) begin
      tx_busy_valid = 0;
      pulse(0, 0, 1, 0);
      chk("R6 frz code", code_of(3), K_ABT); chk("R6 frz flag", mb_flag[3], 1);
    end else begin
      pulse(0, 0, 0, 1);
      chk("R7 done code", code_of(3), K_DONE); chk("R7 done flag", mb_flag[3], 1);
      flag_clr = 4'b1000; @(negedge clk); flag_clr = '0;
      pulse(1, 0, 0, 0);
      chk("R7 dropped code", code_of(3), K_DONE);
      chk("R7 dropped flag", mb_flag[3], 0);
    end
  endtask

  task automatic t_plain();
    do_reset(); abort_en = 1;
    wr(0, K_ACT); lock(0);
    pulse(1, 0, 0, 0);
    chk("R8 arb no req code", code_of(0), K_ACT);
    pulse(0, 1, 0, 0);
    chk("R8 err no req flag", mb_flag[0], 0);
    pulse(0, 0, 0, 1);
    chk("R8 done code", code_of(0), K_DONE);
    chk("R8 done flag", mb_flag[0], 1);
  endtask

  task automatic t_irq_and_clear();
    do_reset();
    wr(1, K_ACT); lock(1); pulse(0, 0, 0, 1);
    chk("R9 masked", irq, 0);
    irq_en = 4'b0001; #1;
    chk("R9 other enable", irq, 0);
    irq_en = 4'b0010; #1;
    chk("R9 enabled", irq, 1);
    @(negedge clk);
    flag_clr = 4'b0010; @(negedge clk); flag_clr = '0;
    chk("R10 cleared", mb_flag[1], 0);
    chk("R9 after clear", irq, 0);
    flag_clr = 4'b0010; ev_tx_done = 1;
    @(negedge clk); flag_clr = '0; ev_tx_done = 0;
    chk("R10 set wins", mb_flag[1], 1);
  endtask

  task automatic t_collision();
    do_reset(); abort_en = 1;
    wr(2, K_ACT); lock(2);
    wr_en = 1; wr_idx = 2; wr_code = K_ABT; ev_arb_lost = 1;
    @(negedge clk); wr_en = 0; ev_arb_lost = 0;
    chk("R11 arb code", code_of(2), K_ABT);
    chk("R11 arb flag", mb_flag[2], 1);
    do_reset(); abort_en = 1;
    wr(2, K_ACT); lock(2);
    wr_en = 1; wr_idx = 2; wr_code = K_ABT; ev_tx_done = 1;
    @(negedge clk); wr_en = 0; ev_tx_done = 0;
    chk("R11 done code", code_of(2), K_DONE);
    chk("R11 done flag", mb_flag[2], 1);
    pulse(0, 0, 1, 0);
    chk("R11 no leftover", code_of(2), K_DONE);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_disabled();
    t_idle_abort();
    for (int k = 0; k < 4; k++) t_refused(k);
    t_plain();
    t_irq_and_clear();
    t_collision();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule